// File: doc/BRIEF.md
# Paged Virtual Address Relocation Unit

This block maps 16-bit virtual addresses to 18-bit physical addresses for a processor with a privileged mode and an unprivileged mode. Each mode owns eight pages of 8 KB. For each page a base register gives the page's physical start in 64-byte units, and a descriptor register gives its length in 64-byte blocks, the direction in which it grows, and its access rights. Software loads these registers, the status register and the enable through a small register port.

Each access is checked against its descriptor in the same cycle it is presented. A violation raises the abort output at once and is logged on the next clock edge. Two logging registers keep the reason with the mode and page, and the failing virtual address. Once any reason flag is set, both logging registers hold their contents until software writes the status register. While translation is off, addresses pass through zero-extended, except the top 8 KB window, which goes to the top 8 KB of physical space.

Top module: `mmu_reloc_unit`

## Requirements
- R1: After reset translation is off, every base and descriptor register reads 0 (descriptor access 0 means not resident), and both logging registers read 0.
- R2: With translation off (status bit 0 clear), pa = {2'b00, va}, except when va[15:13] = 7, where pa = {5'b11111, va[12:0]}. Abort stays low.
- R3: With translation on, pa = base*64 + va[12:0], truncated to 18 bits. The base is the 12-bit register picked by mode_user and va[15:13]. pa[5:0] always equals va[5:0].
- R4: Register addresses 0x00-0x0F hold the bases and 0x10-0x1F hold the descriptors. Address bit 3 picks the mode (1 = user) and bits 2:0 pick the page. The user and kernel register sets are independent.
- R5: Descriptor bits 9:8 give access: 2'b11 read/write, 2'b01 read-only, and 2'b00 or 2'b10 not resident. Any access to a non-resident page aborts and sets status bit 15.
- R6: A write to a read-only page aborts and sets status bit 13. A read of that page does not abort.
- R7: Descriptor bits 6:0 hold the length and bit 7 the direction. The block number is va[12:6]. With bit 7 = 0, a block number above the length aborts. With bit 7 = 1, a block number below the length aborts. Either case sets status bit 14. The length is checked only on resident pages.
- R8: Abort is combinational in the cycle of the access. It is asserted only when access_valid is high and translation is on.
- R9: On the clock edge of an abort, if no flag is already set, the status register (address 0x20) takes the flags, the mode in bit 5 and the page in bits 3:1. The failing virtual address goes to address 0x21.
- R10: While any status flag (bits 15:13) is set, later aborts still drive the abort output but change neither logging register.
- R11: A write to 0x20 loads bits 15:13, 5, 3:1 and 0 from the write data. This is how software clears the flags and unfreezes the log. In the same cycle it takes priority over an abort being recorded.
- R12: Reads return base registers in bits 11:0 and descriptors in bits 9:0, with the other bits 0. Writes to 0x21 are ignored. Addresses 0x22-0x3F read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| access_valid | input | 1 | An access is presented this cycle |
| va | input | 16 | Virtual address |
| mode_user | input | 1 | 1 = user register set, 0 = kernel |
| write_acc | input | 1 | 1 = write access, 0 = read |
| pa | output | 18 | Physical address |
| abort | output | 1 | Access violation this cycle |
| reg_wr | input | 1 | Register port write strobe |
| reg_addr | input | 6 | Register port address |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Register port read data (combinational) |

## Verification
The bench targets the edges of the length check:
- the block equal to the length, and the block one past it, in both growth directions. A design that compares the wrong way would pass one block too many or abort one too early.
- base sums that overflow 18 bits, where a design with a wrong adder carry would produce a wrong high part of the address.
- the top-window mapping with translation off.

For the log, the bench sends a second fault while the first is held, which catches a design whose frozen log still updates. It also puts a status write and a fault in the same cycle, which catches a design that lets the fault win. Last, it checks that a violating address with access_valid low neither aborts nor logs.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W    = 16;
  localparam int PA_W    = 18;
  localparam int PAGE_W  = 3;
  localparam int BLK_W   = 7;
  localparam int OFF_W   = 6;
  localparam int BASE_W  = 12;
  localparam int DATA_W  = 16;
  localparam int RADDR_W = 6;
  localparam int NFLAG   = 3;

  // status register layout
  localparam int ST_EN    = 0;
  localparam int ST_PG_LO = 1;
  localparam int ST_MODE  = 5;
  localparam int ST_FL_LO = 13;   // bits 15:13 = {nonres, length, readonly}
  localparam logic [DATA_W-1:0] ST_MASK = 16'hE02F;

  localparam logic [RADDR_W-1:0] ADDR_STAT = 6'h20;
  localparam logic [RADDR_W-1:0] ADDR_AVA  = 6'h21;

  typedef enum logic [1:0] {
    ACC_NONE_A = 2'b00,
    ACC_RDONLY = 2'b01,
    ACC_NONE_B = 2'b10,
    ACC_RDWR   = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e             acc;
    logic             down;
    logic [BLK_W-1:0] len;
  } pdesc_t;
endpackage

// File: rtl/mmu_page_regs.sv
module mmu_page_regs
  import mmu_pkg::*;
#(
  parameter int NPAGE  = 8,
  parameter int NMODE  = 2,
  parameter int BASEW  = 12,
  localparam int NENT  = NPAGE * NMODE,
  localparam int IDXW  = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_base_en,
  input  logic             wr_desc_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [BASEW-1:0] wr_base,
  input  pdesc_t           wr_desc,
  input  logic [IDXW-1:0]  lk_idx,
  output logic [BASEW-1:0] lk_base,
  output pdesc_t           lk_desc,
  input  logic [IDXW-1:0]  rd_idx,
  output logic [BASEW-1:0] rd_base,
  output pdesc_t           rd_desc
);
  logic [BASEW-1:0] base_arr [NENT];
  pdesc_t           desc_arr [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic             base_ce, desc_ce;
    logic [BASEW-1:0] base_q;
    pdesc_t           desc_q;

    always_comb begin
      base_ce = wr_base_en && (wr_idx == IDXW'(e));
      desc_ce = wr_desc_en && (wr_idx == IDXW'(e));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
      end else if (base_ce) begin
        base_q <= wr_base;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        desc_q <= '0;
      end else if (desc_ce) begin
        desc_q <= wr_desc;
      end
    end

    assign base_arr[e] = base_q;
    assign desc_arr[e] = desc_q;
  end

  assign lk_base = base_arr[lk_idx];
  assign lk_desc = desc_arr[lk_idx];
  assign rd_base = base_arr[rd_idx];
  assign rd_desc = desc_arr[rd_idx];
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int BASEW = 12,
  parameter int ADDW  = 4,
  localparam int NSTG = BASEW / ADDW
) (
  input  logic [VA_W-1:0]  va,
  input  logic [BASEW-1:0] base,
  input  pdesc_t           desc,
  input  logic             en,
  input  logic             valid,
  input  logic             wr,
  output logic [PA_W-1:0]  pa,
  output logic [NFLAG-1:0] flags,
  output logic             abort
);
  localparam int TOPW = PA_W - (VA_W - PAGE_W);

  logic [BASEW-1:0] blk_ext;
  logic [BASEW-1:0] hi_sum;
  logic [NSTG-1:0]  cy;
  logic [BLK_W-1:0] blk;
  logic             resident, len_bad, f_nr, f_len, f_ro;

  assign blk     = va[OFF_W +: BLK_W];
  assign blk_ext = BASEW'(blk);
  assign cy[0]   = 1'b0;

  // staged carry adder for base + block number
  for (genvar s = 0; s < NSTG; s++) begin : g_add
    if (s == NSTG - 1) begin : g_last
      assign hi_sum[s*ADDW +: ADDW] = base[s*ADDW +: ADDW] + blk_ext[s*ADDW +: ADDW]
                                      + {{(ADDW-1){1'b0}}, cy[s]};
    end else begin : g_mid
      assign {cy[s+1], hi_sum[s*ADDW +: ADDW]} =
          {1'b0, base[s*ADDW +: ADDW]} + {1'b0, blk_ext[s*ADDW +: ADDW]}
        + {{ADDW{1'b0}}, cy[s]};
    end
  end

  always_comb begin
    if (en) begin
      pa = {hi_sum, va[OFF_W-1:0]};
    end else if (&va[VA_W-1 -: PAGE_W]) begin
      pa = {{TOPW{1'b1}}, va[VA_W-PAGE_W-1:0]};
    end else begin
      pa = PA_W'(va);
    end
  end

  always_comb begin
    resident = desc.acc[0];
    len_bad  = desc.down ? (blk < desc.len) : (blk > desc.len);
    f_nr     = !resident;
    f_len    = resident && len_bad;
    f_ro     = resident && (desc.acc == ACC_RDONLY) && wr;
    flags    = (en && valid) ? {f_nr, f_len, f_ro} : '0;
    abort    = |flags;
  end
endmodule

// File: rtl/mmu_abort_stat.sv
module mmu_abort_stat
  import mmu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rec,
  input  logic [NFLAG-1:0]  flags,
  input  logic              mode,
  input  logic [PAGE_W-1:0] page,
  input  logic [VA_W-1:0]   va,
  output logic [DATA_W-1:0] stat_q,
  output logic [VA_W-1:0]   ava_q,
  output logic              frozen,
  output logic              reloc_en
);
  logic [DATA_W-1:0] stat_d;
  logic [VA_W-1:0]   ava_d;
  logic              stat_ce, ava_ce;

  assign frozen   = |stat_q[ST_FL_LO +: NFLAG];
  assign reloc_en = stat_q[ST_EN];

  always_comb begin
    stat_d  = stat_q;
    ava_d   = ava_q;
    stat_ce = 1'b0;
    ava_ce  = 1'b0;
    if (stat_wr) begin
      stat_d  = wdata & ST_MASK;
      stat_ce = 1'b1;
    end else if (rec && !frozen) begin
      stat_d[ST_FL_LO +: NFLAG] = flags;
      stat_d[ST_MODE]           = mode;
      stat_d[ST_PG_LO +: PAGE_W] = page;
      stat_ce = 1'b1;
      ava_d   = va;
      ava_ce  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ava_q <= '0;
    end else if (ava_ce) begin
      ava_q <= ava_d;
    end
  end
endmodule

// File: rtl/mmu_reloc_unit.sv
module mmu_reloc_unit
  import mmu_pkg::*;
#(
  parameter int NPAGE = 8,
  parameter int NMODE = 2,
  parameter int ADDW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 access_valid,
  input  logic [VA_W-1:0]      va,
  input  logic                 mode_user,
  input  logic                 write_acc,
  output logic [PA_W-1:0]      pa,
  output logic                 abort,
  input  logic                 reg_wr,
  input  logic [RADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam int IDXW = $clog2(NPAGE * NMODE);
  localparam int DESW = $bits(pdesc_t);

  logic [IDXW-1:0]   lk_idx, rg_idx;
  logic [BASE_W-1:0] lk_base, rd_base;
  pdesc_t            lk_desc, rd_desc;
  logic              wr_base_en, wr_desc_en, stat_wr;
  logic [NFLAG-1:0]  flags;
  logic [DATA_W-1:0] stat_q;
  logic [VA_W-1:0]   ava_q;
  logic              frozen, reloc_en;

  assign lk_idx     = {mode_user, va[VA_W-1 -: PAGE_W]};
  assign rg_idx     = reg_addr[IDXW-1:0];
  assign wr_base_en = reg_wr && (reg_addr[RADDR_W-1 -: 2] == 2'b00);
  assign wr_desc_en = reg_wr && (reg_addr[RADDR_W-1 -: 2] == 2'b01);
  assign stat_wr    = reg_wr && (reg_addr == ADDR_STAT);

  mmu_page_regs #(.NPAGE(NPAGE), .NMODE(NMODE), .BASEW(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_base_en(wr_base_en), .wr_desc_en(wr_desc_en), .wr_idx(rg_idx),
    .wr_base(reg_wdata[BASE_W-1:0]), .wr_desc(pdesc_t'(reg_wdata[DESW-1:0])),
    .lk_idx(lk_idx), .lk_base(lk_base), .lk_desc(lk_desc),
    .rd_idx(rg_idx), .rd_base(rd_base), .rd_desc(rd_desc)
  );

  mmu_xlate #(.BASEW(BASE_W), .ADDW(ADDW)) u_xlate (
    .va(va), .base(lk_base), .desc(lk_desc), .en(reloc_en),
    .valid(access_valid), .wr(write_acc),
    .pa(pa), .flags(flags), .abort(abort)
  );

  mmu_abort_stat u_stat (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .wdata(reg_wdata),
    .rec(abort), .flags(flags), .mode(mode_user),
    .page(va[VA_W-1 -: PAGE_W]), .va(va),
    .stat_q(stat_q), .ava_q(ava_q), .frozen(frozen), .reloc_en(reloc_en)
  );

  always_comb begin
    if (reg_addr[RADDR_W-1 -: 2] == 2'b00) begin
      reg_rdata = DATA_W'(rd_base);
    end else if (reg_addr[RADDR_W-1 -: 2] == 2'b01) begin
      reg_rdata = DATA_W'(rd_desc);
    end else if (reg_addr == ADDR_STAT) begin
      reg_rdata = stat_q;
    end else if (reg_addr == ADDR_AVA) begin
      reg_rdata = DATA_W'(ava_q);
    end else begin
      reg_rdata = '0;
    end
  end
endmodule

// File: rtl/mmu_chk.sv
module mmu_chk
  import mmu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               access_valid,
  input logic [VA_W-1:0]    va,
  input logic [PA_W-1:0]    pa,
  input logic               abort,
  input logic               reg_wr,
  input logic [RADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0]  stat_q,
  input logic [VA_W-1:0]    ava_q,
  input logic               reloc_en
);
  logic frz, swr;
  assign frz = |stat_q[15:13];
  assign swr = reg_wr && (reg_addr == ADDR_STAT);

  // R8
  abort_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (access_valid && reloc_en));

  // R3
  offset_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reloc_en |-> (pa[5:0] == va[5:0]));

  // R2
  top_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reloc_en && (va[15:13] == 3'b111)) |-> (pa[17:13] == 5'h1f) && !abort);

  // R9
  record_va_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !frz && !swr) |=> (ava_q == $past(va)) && (stat_q[15:13] != 3'b000));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && !swr) |=> $stable(ava_q) && $stable(stat_q));

  // R11
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swr && (reg_wdata[15:13] == 3'b000)) |=> (stat_q[15:13] == 3'b000));
endmodule

bind mmu_reloc_unit mmu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .access_valid(access_valid), .va(va), .pa(pa),
  .abort(abort), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .stat_q(stat_q), .ava_q(ava_q), .reloc_en(reloc_en)
);

// File: tb/mmu_reloc_unit_tb.sv
`timescale 1ns/1ps
module mmu_reloc_unit_tb;
  logic        clk, rst_n, access_valid, mode_user, write_acc, abort, reg_wr;
  logic [15:0] va, reg_wdata, reg_rdata;
  logic [17:0] pa;
  logic [5:0]  reg_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] m_base [16];
  logic [9:0]  m_desc [16];
  logic [15:0] m_stat, m_ava;

  mmu_reloc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .access_valid(access_valid), .va(va),
    .mode_user(mode_user), .write_acc(write_acc), .pa(pa), .abort(abort),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_flags(input logic [15:0] v, input logic m, input logic w);
    logic [3:0] idx;
    logic [9:0] d;
    logic [2:0] f;
    idx = {m, v[15:13]};
    d = m_desc[idx];
    f = 3'b000;
    if (!m_stat[0]) return 3'b000;
    if (!d[8]) return 3'b100;
    if (d[7] ? (v[12:6] < d[6:0]) : (v[12:6] > d[6:0])) f[1] = 1'b1;
    if (d[9:8] == 2'b01 && w) f[0] = 1'b1;
    return f;
  endfunction

  function automatic logic [17:0] exp_pa(input logic [15:0] v, input logic m);
    logic [17:0] s;
    if (!m_stat[0]) return (v[15:13] == 3'b111) ? {5'h1f, v[12:0]} : {2'b00, v};
    s = {m_base[{m, v[15:13]}], 6'b0} + {5'b0, v[12:0]};
    return s;
  endfunction

  function automatic logic [15:0] m_read(input logic [5:0] a);
    if (a[5:4] == 2'b00) return {4'b0, m_base[a[3:0]]};
    if (a[5:4] == 2'b01) return {6'b0, m_desc[a[3:0]]};
    if (a == 6'h20) return m_stat;
    if (a == 6'h21) return m_ava;
    return 16'h0;
  endfunction

  task automatic reg_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a[5:4] == 2'b00) m_base[a[3:0]] = d[11:0];
    else if (a[5:4] == 2'b01) m_desc[a[3:0]] = d[9:0];
    else if (a == 6'h20) m_stat = d & 16'hE02F;
    #1 reg_wr = 0;
  endtask

  task automatic reg_check(input logic [5:0] a, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, reg_rdata, m_read(a));
  endtask

  task automatic do_acc(input logic [15:0] v, input logic m, input logic w,
                        input logic vld, input string tag);
    logic [2:0] f;
    @(negedge clk);
    va = v; mode_user = m; write_acc = w; access_valid = vld;
    f = vld ? exp_flags(v, m, w) : 3'b000;
    #2;
    chk({tag, " pa"}, pa, exp_pa(v, m));
    chk({tag, " abort"}, abort, |f);
    @(posedge clk);
    if (|f && m_stat[15:13] == 3'b000) begin
      m_stat[15:13] = f;
      m_stat[5] = m;
      m_stat[3:1] = v[15:13];
      m_ava = v;
    end
    #1 access_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; access_valid = 0; va = 0; mode_user = 0; write_acc = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_desc[i] = 0; end
    m_stat = 0; m_ava = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_check(6'h00, "R1 base0");
    reg_check(6'h1f, "R1 desc15");
    reg_check(6'h20, "R1 status");
    reg_check(6'h21, "R1 abort va");

    // R2 pass-through
    do_acc(16'hffff, 0, 1, 1, "R2 top window");
    do_acc(16'h1234, 1, 0, 1, "R2 low");
    do_acc(16'hc000, 0, 0, 1, "R2 below top");
    for (int i = 0; i < 20; i++) do_acc(16'($urandom), 1'($urandom), 1'($urandom), 1, "R2 rand");

    // R12 register port details
    reg_write(6'h21, 16'hbeef);
    reg_check(6'h21, "R12 ava write ignored");
    reg_write(6'h30, 16'h5555);
    reg_check(6'h30, "R12 unused addr");
    reg_check(6'h22, "R12 unused addr2");
    reg_write(6'h05, 16'hffff);
    reg_check(6'h05, "R12 base width");
    reg_write(6'h15, 16'hffff);
    reg_check(6'h15, "R12 desc width");

    // setup: random bases, all full read/write pages, enable
    for (int i = 0; i < 16; i++) begin
      reg_write(6'(i), 16'($urandom));
      reg_write(6'(16 + i), 16'h037f);
    end
    reg_write(6'h20, 16'h0001);
    for (int i = 0; i < 30; i++) do_acc(16'($urandom), 1'($urandom), 1'($urandom), 1, "R3 rand");

    // R4 separate mode sets, same page
    reg_write(6'h02, 16'h0100);
    reg_write(6'h0a, 16'h0200);
    do_acc(16'h4123, 0, 0, 1, "R4 kernel");
    chk("R4 kernel literal", pa, 18'h04123);
    do_acc(16'h4123, 1, 0, 1, "R4 user");
    chk("R4 user literal", pa, 18'h08123);
    // R3 wrap past 18 bits
    reg_write(6'h07, 16'h0fff);
    do_acc(16'hffff, 0, 0, 1, "R3 wrap");

    // R5 non-resident (both codes)
    reg_write(6'h12, 16'h007f);
    do_acc(16'h4000, 0, 0, 1, "R5 nonres 00");
    reg_check(6'h20, "R5 status");
    reg_check(6'h21, "R9 abort va");
    reg_write(6'h20, 16'h0001);
    reg_check(6'h20, "R11 cleared");
    reg_write(6'h12, 16'h027f);
    do_acc(16'h4040, 0, 0, 1, "R5 nonres 10");
    reg_check(6'h20, "R5 status2");
    reg_write(6'h20, 16'h0001);

    // R6 read-only
    reg_write(6'h1b, 16'h017f);
    do_acc(16'h6100, 1, 0, 1, "R6 ro read");
    do_acc(16'h6100, 1, 1, 1, "R6 ro write");
    reg_check(6'h20, "R6 status");
    reg_check(6'h21, "R9 abort va2");
    reg_write(6'h20, 16'h0001);

    // R7 length, upward
    reg_write(6'h13, 16'h0305);
    do_acc(16'h6000 | (16'd5 << 6), 0, 1, 1, "R7 up at len");
    do_acc(16'h6000 | (16'd6 << 6), 0, 1, 1, "R7 up past len");
    reg_check(6'h20, "R7 status");
    reg_write(6'h20, 16'h0001);
    // R7 length, downward
    reg_write(6'h13, 16'h0385);
    do_acc(16'h6000 | (16'd5 << 6), 0, 0, 1, "R7 down at len");
    do_acc(16'h6000 | (16'd4 << 6), 0, 0, 1, "R7 down below len");
    reg_check(6'h20, "R7 status down");

    // R10 frozen: second fault must not overwrite
    do_acc(16'h4000, 0, 1, 1, "R10 second fault");
    reg_check(6'h20, "R10 status held");
    reg_check(6'h21, "R10 va held");

    // R11 status write beats fault in same cycle
    @(negedge clk);
    va = 16'h4000; mode_user = 0; write_acc = 0; access_valid = 1;
    reg_wr = 1; reg_addr = 6'h20; reg_wdata = 16'h0001;
    @(posedge clk);
    m_stat = 16'h0001;
    #1 access_valid = 0; reg_wr = 0;
    reg_check(6'h20, "R11 write wins");
    reg_check(6'h21, "R11 va unchanged");

    // R8 no abort without access_valid
    do_acc(16'h4000, 0, 0, 0, "R8 invalid");
    reg_check(6'h20, "R8 not logged");

    // mixed random phase
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 12);
      if (r < 2) reg_write(6'($urandom % 16), 16'($urandom));
      else if (r < 4) reg_write(6'(16 + $urandom % 16), 16'($urandom));
      else if (r == 4) reg_write(6'h20, (16'($urandom) & 16'h002e) | 16'h0001);
      else if (r == 5) reg_check(6'($urandom), "R12 rand read");
      else do_acc(16'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) != 0, "R7 rand access");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule